// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-clocked watchdog with a refresh window. A 7-bit down-counter is decremented once every `2^BASE_LOG2 × 2^tbase` bus clock cycles. `tbase` is a 2-bit timebase field, and the default base is 4096 cycles. Software arms the watchdog by setting the arm bit in the control register. Once armed, software must keep reloading the counter before bit 6 of the counter clears. Bit 6 clearing is the expiry: the counter steps from 0x40 to 0x3F. The block also rejects reloads that come too early, while the counter is still above a programmed window value. Expiry and every rejected reload produce a one-cycle reset request.

An optional early-warning flag is set when the counter reaches 0x40, one decrement before expiry. The interrupt output follows this flag. Software clears it by writing zero. While the processor is halted for debug, the timebase either keeps running or freezes, as chosen by an external input. Registers sit on a simple 32-bit bus with byte-lane enables, so both 16-bit and 32-bit accesses work.

Top module: `winwdg_top`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0000_007F, the configuration register (offset 0x4) reads 0x0000_007F, the status register (offset 0x8) reads 0, and `rst_req` and `irq_early` are low.
- R2: While armed and not frozen, the counter (control bits 6:0) decrements by one every `2^BASE_LOG2 × 2^tbase` clock cycles, where `tbase` is configuration bits 9:8. Every control write restarts the timebase, so the first decrement after a reload comes a full period later.
- R3: When an armed counter steps from 0x40 to 0x3F, `rst_req` is high for exactly one cycle. For a reload value T (T ≥ 0x40), this happens `(T − 63)` periods after the write.
- R4: A control write whose bit 6 is 0 raises `rst_req` for one cycle if the watchdog was armed or the same write sets the arm bit (control bit 7). Otherwise it raises nothing.
- R5: A control write made while armed and while the counter is greater than the window (configuration bits 6:0) raises `rst_req` for one cycle. A counter equal to or below the window is accepted.
- R6: The arm bit can only be set. Writing 0 to control bit 7 leaves the block armed, and only `rst_n` disarms it.
- R7: If the early-warning enable (configuration bit 10) is set, the status flag (status bit 0) is set when the counter decrements to 0x40, and `irq_early` follows the flag. With the enable clear, the flag stays 0. A pending warning does not stop the expiry reset.
- R8: Writing status bit 0 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R9: While `dbg_halt` and `dbg_freeze_en` are both high, the counter and timebase hold their values. With `dbg_freeze_en` low, a halt has no effect.
- R10: Byte lane 0 (`bus_be[0]`) writes bits 7:0 and lane 1 writes bits 15:8. Lanes 2–3 and all reserved bits are ignored, and reserved bits read 0.
- R11: While not armed, the counter does not decrement and expiry produces no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset (0x0 control, 0x4 configuration, 0x8 status) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while selected for read |
| dbg_halt | input | 1 | Processor halted in debug |
| dbg_freeze_en | input | 1 | Freeze the timebase during a debug halt |
| irq_early | output | 1 | Early-warning interrupt (status flag) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `BASE_LOG2 = 2`, so one decrement period is 4, 8, 16 or 32 cycles instead of 4096 to 32768. This small base lets the bench sweep all four timebase codes against several reload values and compare each measured expiry time to `(T − 63) × 4 × 2^tbase`. It also brings the early-warning, window and debug-freeze sequences within a few dozen cycles, so each one can be checked exactly at the cycle where the arithmetic places it.

// File: rtl/winwdg_pkg.sv
package winwdg_pkg;

    localparam int BUS_W = 32;
    localparam int CNT_W = 7;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;

    localparam logic [CNT_W-1:0] CNT_RESET  = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_EXPIRE = 7'h40;
    localparam logic [CNT_W-1:0] CNT_WARN   = 7'h41;

    typedef struct packed {
        logic [CNT_W-1:0] window;
        logic [1:0]       tbase;
        logic             ew_en;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic flag;
    } regs_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             active;
        logic             rst;
    } core_st_t;

endpackage

// File: rtl/winwdg_prescaler.sv
module winwdg_prescaler #(
    parameter int BASE_LOG2 = 12,
    localparam int PRE_W = BASE_LOG2 + 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] tbase,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_d;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (PRE_W'(1) << (BASE_LOG2 + int'(tbase))) - PRE_W'(1);
        tick  = run && !restart && (pre_q >= limit);
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R9: a stopped timebase keeps its phase
    a_r9_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(pre_q));

    // R2: a restart always lands on phase zero
    a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));

endmodule

// File: rtl/winwdg_core.sv
module winwdg_core
    import winwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_data,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             rst_req,
    output logic             ew_hit
);

    core_st_t s_q;
    core_st_t s_d;
    logic     expire;
    logic     bad_write;
    logic     arming;

    always_comb begin
        s_d       = s_q;
        arming    = s_q.active || ctrl_data[7];
        expire    = tick && s_q.active && (s_q.count == CNT_EXPIRE);
        ew_hit    = tick && s_q.active && (s_q.count == CNT_WARN);
        bad_write = ctrl_wr && ((arming && !ctrl_data[6]) ||
                                (s_q.active && (s_q.count > window)));
        if (ctrl_wr) begin
            s_d.count  = ctrl_data[CNT_W-1:0];
            s_d.active = arming;
        end else if (tick && s_q.active) begin
            s_d.count = s_q.count - CNT_W'(1);
        end
        s_d.rst = expire || bad_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{count: CNT_RESET, active: 1'b0, rst: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.count;
    assign active  = s_q.active;
    assign rst_req = s_q.rst;

    // R6: arming is sticky
    a_r6_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |=> s_q.active);

    // R11: idle counter never moves on its own
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !ctrl_wr) |=> $stable(s_q.count));

    // R2: without a write the counter only holds or steps down by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ((s_q.count == $past(s_q.count)) ||
                      (s_q.count == $past(s_q.count) - CNT_W'(1))));

    // R3: the 0x40 -> 0x3F step is always accompanied by a reset request
    a_r3_expiry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.count) == CNT_EXPIRE && s_q.count == 7'h3F && !$past(ctrl_wr))
        |-> s_q.rst);

endmodule

// File: rtl/winwdg_regs.sv
module winwdg_regs
    import winwdg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              ew_hit,
    input  logic [CNT_W-1:0]  count,
    input  logic              active,
    output cfg_t              cfg,
    output logic              flag,
    output logic              ctrl_wr,
    output logic [7:0]        ctrl_data,
    output logic [BUS_W-1:0]  bus_rdata
);

    regs_st_t    r_q;
    regs_st_t    r_d;
    logic        wr_lo;
    logic        wr_hi;
    logic [3:0]  ofs;
    logic        clr_req;

    always_comb begin
        ofs     = 4'(bus_addr);
        wr_lo   = bus_sel && bus_wr && bus_be[0];
        wr_hi   = bus_sel && bus_wr && bus_be[1];
        ctrl_wr   = wr_lo && (ofs == OFS_CTRL);
        ctrl_data = bus_wdata[7:0];
        clr_req = wr_lo && (ofs == OFS_STAT) && !bus_wdata[0];

        r_d = r_q;
        if (wr_lo && ofs == OFS_CFG) begin
            r_d.cfg.window = bus_wdata[CNT_W-1:0];
        end
        if (wr_hi && ofs == OFS_CFG) begin
            r_d.cfg.tbase = bus_wdata[9:8];
            r_d.cfg.ew_en = bus_wdata[10];
        end
        if (clr_req) begin
            r_d.flag = 1'b0;
        end
        if (ew_hit && r_q.cfg.ew_en) begin
            r_d.flag = 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (ofs)
                OFS_CTRL: bus_rdata[7:0] = {active, count};
                OFS_CFG: begin
                    bus_rdata[CNT_W-1:0] = r_q.cfg.window;
                    bus_rdata[9:8]       = r_q.cfg.tbase;
                    bus_rdata[10]        = r_q.cfg.ew_en;
                end
                OFS_STAT: bus_rdata[0] = r_q.flag;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cfg: '{window: CNT_RESET, tbase: 2'd0, ew_en: 1'b0},
                     flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg  = r_q.cfg;
    assign flag = r_q.flag;

    // R8: the flag only falls on a zero write
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !clr_req) |=> r_q.flag);

    // R7: the flag only rises with the enable set
    a_r7_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(r_q.cfg.ew_en));

endmodule

// File: rtl/winwdg_top.sv
module winwdg_top
    import winwdg_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_halt,
    input  logic              dbg_freeze_en,
    output logic              irq_early,
    output logic              rst_req
);

    cfg_t             cfg;
    logic             flag;
    logic             ctrl_wr;
    logic [7:0]       ctrl_data;
    logic [CNT_W-1:0] count;
    logic             active;
    logic             ew_hit;
    logic             tick;
    logic             run;

    assign run       = active && !(dbg_halt && dbg_freeze_en);
    assign irq_early = flag;

    winwdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .ew_hit    (ew_hit),
        .count     (count),
        .active    (active),
        .cfg       (cfg),
        .flag      (flag),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_data),
        .bus_rdata (bus_rdata)
    );

    winwdg_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ctrl_wr),
        .tbase   (cfg.tbase),
        .tick    (tick)
    );

    winwdg_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_data),
        .window    (cfg.window),
        .count     (count),
        .active    (active),
        .rst_req   (rst_req),
        .ew_hit    (ew_hit)
    );

    // R9: a frozen armed counter does not move without a write
    a_r9_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && dbg_freeze_en && !ctrl_wr) |=> $stable(count));

endmodule

// File: tb/tb_winwdg_top.sv
`timescale 1ns/1ps
module tb_winwdg_top;

    localparam int BL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        dbg_freeze_en = 1'b0;
    logic        irq_early;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    winwdg_top #(.BASE_LOG2(BL), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en),
        .irq_early(irq_early), .rst_req(rst_req)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dbg_halt = 1'b0;
        dbg_freeze_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        int p;
        logic [7:0] tv [3];
        tv[0] = 8'h41; tv[1] = 8'h44; tv[2] = 8'h48;

        // R1 reset values
        do_reset();
        rd(4'h0, v); check("R1 ctrl", v, 32'h7F);
        rd(4'h4, v); check("R1 cfg", v, 32'h7F);
        rd(4'h8, v); check("R1 stat", v, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 0);
        check("R1 irq", {31'b0, irq_early}, 0);

        // R11 idle counter holds
        wait_edges(50);
        rd(4'h0, v); check("R11 idle count", v, 32'h7F);
        check("R11 no reset", {31'b0, rst_req}, 0);

        // R3 / R2 expiry timing sweep
        for (int tb = 0; tb < 4; tb++) begin
            p = (1 << BL) << tb;
            for (int k = 0; k < 3; k++) begin
                do_reset();
                wr(4'h4, 4'b0010, 32'(tb) << 8);
                wr(4'h0, 4'b0001, {24'b0, tv[k] | 8'h80});
                n = 0;
                while (!rst_req && n < 2000) begin
                    @(negedge clk);
                    n++;
                end
                check("R3 expiry time", n, (int'(tv[k]) - 63) * p);
                rd(4'h0, v); check("R2 count after expiry", v, 32'hBF);
                @(negedge clk);
                check("R3 pulse width", {31'b0, rst_req}, 0);
            end
            // R2 prescaler restarts on reload
            do_reset();
            wr(4'h4, 4'b0010, 32'(tb) << 8);
            wr(4'h0, 4'b0001, 32'hF0);
            wait_edges(p - 2);
            wr(4'h0, 4'b0001, 32'hF0);
            wait_edges(p - 1);
            rd(4'h0, v); check("R2 full period after reload", v, 32'hF0);
            wait_edges(1);
            rd(4'h0, v); check("R2 decrement", v, 32'hEF);
        end

        // R4 bit 6 clear writes
        do_reset();
        wr(4'h0, 4'b0001, 32'h3F);
        check("R4 unarmed low write", {31'b0, rst_req}, 0);
        wr(4'h0, 4'b0001, 32'hBF);
        check("R4 arming low write", {31'b0, rst_req}, 1);
        do_reset();
        wr(4'h0, 4'b0001, 32'hFF);
        wr(4'h0, 4'b0001, 32'hA0);
        check("R4 armed low write", {31'b0, rst_req}, 1);
        @(negedge clk);
        check("R4 pulse width", {31'b0, rst_req}, 0);

        // R5 window
        do_reset();
        wr(4'h4, 4'b0001, 32'h50);
        wr(4'h0, 4'b0001, 32'hE0);
        check("R5 first arm", {31'b0, rst_req}, 0);
        wr(4'h0, 4'b0001, 32'hE0);
        check("R5 early refresh", {31'b0, rst_req}, 1);
        do_reset();
        wr(4'h4, 4'b0001, 32'h50);
        wr(4'h0, 4'b0001, 32'hD0);
        wr(4'h0, 4'b0001, 32'hD0);
        check("R5 refresh at window", {31'b0, rst_req}, 0);

        // R6 sticky arm
        do_reset();
        wr(4'h0, 4'b0001, 32'hFF);
        wr(4'h0, 4'b0001, 32'h7F);
        rd(4'h0, v); check("R6 arm kept", v, 32'hFF);
        check("R6 no reset", {31'b0, rst_req}, 0);

        // R7 / R8 early warning
        do_reset();
        wr(4'h4, 4'b0010, 32'h400);
        wr(4'h0, 4'b0001, 32'hC2);
        wait_edges(7);
        check("R7 irq before 0x40", {31'b0, irq_early}, 0);
        wait_edges(1);
        check("R7 irq at 0x40", {31'b0, irq_early}, 1);
        rd(4'h8, v); check("R7 stat flag", v, 32'h1);
        wr(4'h8, 4'b0001, 32'h1);
        check("R8 write one keeps", {31'b0, irq_early}, 1);
        wr(4'h8, 4'b0001, 32'h0);
        check("R8 write zero clears", {31'b0, irq_early}, 0);
        wait_edges(1);
        check("R7 reset not yet", {31'b0, rst_req}, 0);
        wait_edges(1);
        check("R7 reset still follows", {31'b0, rst_req}, 1);
        do_reset();
        wr(4'h0, 4'b0001, 32'hC2);
        wait_edges(9);
        check("R7 disabled irq", {31'b0, irq_early}, 0);
        rd(4'h8, v); check("R7 disabled flag", v, 32'h0);

        // R9 debug freeze
        do_reset();
        dbg_halt = 1'b1; dbg_freeze_en = 1'b1;
        wr(4'h0, 4'b0001, 32'hF0);
        wait_edges(40);
        rd(4'h0, v); check("R9 frozen", v, 32'hF0);
        dbg_freeze_en = 1'b0;
        wait_edges(4);
        rd(4'h0, v); check("R9 halt without freeze counts", v, 32'hEF);
        dbg_halt = 1'b0;

        // R10 byte lanes
        do_reset();
        wr(4'h4, 4'b1100, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R10 upper lanes ignored", v, 32'h7F);
        wr(4'h4, 4'b0010, 32'h0000_0300);
        rd(4'h4, v); check("R10 lane1 cfg", v, 32'h37F);
        wr(4'h4, 4'b0001, 32'h0000_0711);
        rd(4'h4, v); check("R10 lane0 cfg", v, 32'h311);
        wr(4'h0, 4'b0010, 32'h0000_FF00);
        rd(4'h0, v); check("R10 ctrl lane1 ignored", v, 32'h7F);
        wr(4'h0, 4'b1111, 32'h1234_0055);
        rd(4'h0, v); check("R10 word write reserved zero", v, 32'h55);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule